// File: doc/BRIEF.md
# Floating-Point Register Boxing Unit

This unit sits between a 64-bit floating-point register file and arithmetic units that work on 16-bit or 32-bit formats. On the write path it widens a narrow result to a full 64-bit register value by setting every bit above the narrow field to one. On the read path it tests a 64-bit register operand for that pattern. A correctly boxed operand passes through unchanged. An operand with any zero above the narrow field is replaced by the canonical quiet NaN of the requested width, and that NaN is boxed too.

Boxing is applied for every narrow format, whether or not double precision is present in the surrounding datapath. A double-width select leaves the value untouched in both directions. The result is available at once on a combinational output, and one clock later on a registered output with a valid strobe. The registered output keeps its value while no new operation is presented.

Top module: `fp_box_unit`

## Requirements
- R1: With dir_i = 0 (box) and fmt_i = 2'b01 (single), comb_o[63:32] is all ones and comb_o[31:0] equals value_i[31:0].
- R2: With dir_i = 0 (box) and fmt_i = 2'b00 (half), comb_o[63:16] is all ones and comb_o[15:0] equals value_i[15:0].
- R3: With dir_i = 1 (check) and a narrow fmt_i, an operand whose bits above the narrow field are all ones appears on comb_o unchanged.
- R4: With dir_i = 1 and fmt_i = 2'b01, an operand with any zero in bits 63..32 yields comb_o = 64'hFFFFFFFF_7FC00000.
- R5: With dir_i = 1 and fmt_i = 2'b00, an operand with any zero in bits 63..16 yields comb_o = 64'hFFFFFFFF_FFFF7E00.
- R6: With fmt_i[1] = 1 (double), comb_o equals value_i for both directions.
- R7: When in_valid_i is high at a rising clock edge, reg_o takes the value comb_o had at that edge and reg_valid_o is high for the following cycle; reg_valid_o is low after an edge with in_valid_i low, and reg_o then keeps its value.
- R8: While rst_ni is low, reg_valid_o is 0 and reg_o is all zeros.
- R9: With dir_i = 1 and a narrow fmt_i, comb_o is always boxed: every bit above the narrow field is one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operation present this cycle |
| value_i | input | 64 | Register value or narrow result |
| fmt_i | input | 2 | 00 half, 01 single, 1x double |
| dir_i | input | 1 | 0 box for write, 1 check for read |
| comb_o | output | 64 | Combinational result |
| reg_o | output | 64 | Registered result |
| reg_valid_o | output | 1 | Registered result is new this cycle |

## Verification
The registered output delivers the previous operation while the combinational output already carries a new one, so the two paths can hold results of different formats and directions in the same cycle. The bench provokes this with back-to-back operations that change format, direction and box validity every cycle, interleaved with idle cycles. A behavioural model keeps a queue of expected registered values. On every clock it judges both outputs at once, so a mix-up between the two paths shows as a mismatch.

// File: rtl/fp_box_pkg.sv
package fp_box_pkg;
  localparam int unsigned FLEN    = 64;
  localparam int unsigned N_NARROW = 2;

  typedef enum logic [1:0] {
    FMT_HALF = 2'b00,
    FMT_SGL  = 2'b01,
    FMT_DBL  = 2'b10,
    FMT_DBLX = 2'b11
  } fmt_e;

  function automatic int unsigned narrow_width(input int unsigned idx);
    return (idx == 0) ? 16 : 32;
  endfunction

  function automatic logic [31:0] narrow_qnan(input int unsigned idx);
    return (idx == 0) ? 32'h0000_7E00 : 32'h7FC0_0000;
  endfunction
endpackage

// File: rtl/fp_box_write.sv
module fp_box_write #(
  parameter int unsigned FLEN = 64,
  parameter int unsigned NW   = 32
) (
  input  logic [FLEN-1:0] val_i,
  output logic [FLEN-1:0] boxed_o
);
  localparam int unsigned PADW = FLEN - NW;
  assign boxed_o = {{PADW{1'b1}}, val_i[NW-1:0]};
endmodule

// File: rtl/fp_box_check.sv
module fp_box_check #(
  parameter int unsigned FLEN  = 64,
  parameter int unsigned NW    = 32,
  parameter logic [31:0] QNAN  = 32'h7FC0_0000
) (
  input  logic [FLEN-1:0] val_i,
  output logic [FLEN-1:0] chk_o
);
  localparam int unsigned PADW = FLEN - NW;
  logic box_ok;
  assign box_ok = &val_i[FLEN-1:NW];
  // substituted NaN is itself boxed
  assign chk_o = box_ok ? val_i : {{PADW{1'b1}}, QNAN[NW-1:0]};
endmodule

// File: rtl/fp_box_outreg.sv
module fp_box_outreg #(
  parameter int unsigned FLEN    = 64,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            vld_i,
  input  logic [FLEN-1:0] d_i,
  output logic [FLEN-1:0] q_o,
  output logic            vld_o
);
  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        q_o   <= '0;
        vld_o <= 1'b0;
      end else begin
        vld_o <= vld_i;
        if (vld_i) q_o <= d_i;
      end
    end
  end else begin : g_bypass
    assign q_o   = d_i;
    assign vld_o = vld_i;
  end
endmodule

// File: rtl/fp_box_unit.sv
module fp_box_unit
  import fp_box_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            in_valid_i,
  input  logic [FLEN-1:0] value_i,
  input  logic [1:0]      fmt_i,
  input  logic            dir_i,
  output logic [FLEN-1:0] comb_o,
  output logic [FLEN-1:0] reg_o,
  output logic            reg_valid_o
);
  logic [FLEN-1:0] wr_res [N_NARROW];
  logic [FLEN-1:0] rd_res [N_NARROW];

  for (genvar g = 0; g < N_NARROW; g++) begin : g_narrow
    localparam int unsigned NW   = narrow_width(g);
    localparam logic [31:0] QNAN = narrow_qnan(g);

    fp_box_write #(.FLEN(FLEN), .NW(NW)) u_wr (
      .val_i   (value_i),
      .boxed_o (wr_res[g])
    );
    fp_box_check #(.FLEN(FLEN), .NW(NW), .QNAN(QNAN)) u_rd (
      .val_i (value_i),
      .chk_o (rd_res[g])
    );
  end

  always_comb begin
    if (fmt_i[1])   comb_o = value_i;
    else if (dir_i) comb_o = rd_res[fmt_i[0]];
    else            comb_o = wr_res[fmt_i[0]];
  end

  fp_box_outreg #(.FLEN(FLEN), .REG_OUT(REG_OUT)) u_out (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .vld_i  (in_valid_i),
    .d_i    (comb_o),
    .q_o    (reg_o),
    .vld_o  (reg_valid_o)
  );
endmodule

// File: rtl/fp_box_unit_chk.sv
module fp_box_unit_chk #(
  parameter bit REG_OUT = 1'b1
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        in_valid_i,
  input logic [63:0] value_i,
  input logic [1:0]  fmt_i,
  input logic        dir_i,
  input logic [63:0] comb_o,
  input logic [63:0] reg_o,
  input logic        reg_valid_o
);
  // R1
  box_sgl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dir_i && fmt_i == 2'b01) |-> (comb_o[63:32] == 32'hFFFF_FFFF && comb_o[31:0] == value_i[31:0]));
  // R2
  box_half_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dir_i && fmt_i == 2'b00) |-> (comb_o[63:16] == 48'hFFFF_FFFF_FFFF && comb_o[15:0] == value_i[15:0]));
  // R4
  bad_sgl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dir_i && fmt_i == 2'b01 && value_i[63:32] != 32'hFFFF_FFFF) |-> comb_o == 64'hFFFF_FFFF_7FC0_0000);
  // R5
  bad_half_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dir_i && fmt_i == 2'b00 && value_i[63:16] != 48'hFFFF_FFFF_FFFF) |-> comb_o == 64'hFFFF_FFFF_FFFF_7E00);
  // R6
  dbl_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fmt_i[1] |-> comb_o == value_i);
  // R9
  unbox_boxed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dir_i && !fmt_i[1]) |-> (fmt_i[0] ? (&comb_o[63:32]) : (&comb_o[63:16])));

  if (REG_OUT) begin : g_reg_chk
    // R7
    reg_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      in_valid_i |=> (reg_valid_o && reg_o == $past(comb_o)));
    // R7
    reg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !in_valid_i |=> (!reg_valid_o && $stable(reg_o)));
  end
endmodule

bind fp_box_unit fp_box_unit_chk #(.REG_OUT(REG_OUT)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .value_i     (value_i),
  .fmt_i       (fmt_i),
  .dir_i       (dir_i),
  .comb_o      (comb_o),
  .reg_o       (reg_o),
  .reg_valid_o (reg_valid_o)
);

// File: tb/fp_box_unit_tb_top.sv
`timescale 1ns/1ps
module fp_box_unit_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid_i = 1'b0;
  logic [63:0] value_i = '0;
  logic [1:0]  fmt_i = 2'b00;
  logic        dir_i = 1'b0;
  logic [63:0] comb_o, reg_o;
  logic        reg_valid_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [63:0] exp_q [$];
  logic [63:0] exp_hold = '0;
  logic        exp_rv = 1'b0;

  always #5 clk_i = ~clk_i;

  fp_box_unit dut_i (
    .clk_i, .rst_ni, .in_valid_i, .value_i, .fmt_i, .dir_i,
    .comb_o, .reg_o, .reg_valid_o
  );

  function automatic logic [63:0] model(input logic [63:0] v, input logic [1:0] f, input logic d);
    if (f[1]) return v;                                   // R6
    if (f == 2'b01) begin
      if (!d) return {32'hFFFF_FFFF, v[31:0]};            // R1
      if (v[63:32] == 32'hFFFF_FFFF) return v;            // R3
      return 64'hFFFF_FFFF_7FC0_0000;                     // R4
    end
    if (!d) return {48'hFFFF_FFFF_FFFF, v[15:0]};         // R2
    if (v[63:16] == 48'hFFFF_FFFF_FFFF) return v;         // R3
    return 64'hFFFF_FFFF_FFFF_7E00;                       // R5
  endfunction

  function automatic string req_of(input logic [63:0] v, input logic [1:0] f, input logic d);
    if (f[1]) return "R6";
    if (!d) return f[0] ? "R1" : "R2";
    if (f[0]) return (v[63:32] == 32'hFFFF_FFFF) ? "R3/R9" : "R4/R9";
    return (v[63:16] == 48'hFFFF_FFFF_FFFF) ? "R3/R9" : "R5/R9";
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one cycle: drive at negedge, judge both paths just after
  task automatic step(input logic vld, input logic [63:0] v, input logic [1:0] f, input logic d);
    logic [63:0] e;
    @(negedge clk_i);
    // registered path result from previous edge (R7)
    check("R7 valid", {63'd0, reg_valid_o}, {63'd0, exp_rv});
    check("R7 data", reg_o, exp_hold);
    in_valid_i = vld; value_i = v; fmt_i = f; dir_i = d;
    #1;
    e = model(v, f, d);
    check(req_of(v, f, d), comb_o, e);
    if (vld) exp_q.push_back(e);
    exp_rv = vld;
    if (vld) exp_hold = exp_q.pop_front();
  endtask

  function automatic logic [63:0] rnd64(input int kind);
    logic [63:0] r;
    r = {$urandom, $urandom};
    case (kind)
      0: r[63:32] = 32'hFFFF_FFFF;
      1: r[63:16] = 48'hFFFF_FFFF_FFFF;
      2: begin r[63:16] = 48'hFFFF_FFFF_FFFF; r[$urandom_range(63,16)] = 1'b0; end
      default: ;
    endcase
    return r;
  endfunction

  initial begin
    #1;
    // R8
    check("R8 valid", {63'd0, reg_valid_o}, 64'd0);
    check("R8 data", reg_o, 64'd0);
    #22 rst_ni = 1'b1;

    step(1, 64'h0123_4567_89AB_CDEF, 2'b01, 0);   // R1
    step(1, 64'h0123_4567_89AB_CDEF, 2'b00, 0);   // R2
    step(1, 64'hFFFF_FFFF_3F80_0000, 2'b01, 1);   // R3
    step(1, 64'hFFFF_FFFF_FFFF_3C00, 2'b00, 1);   // R3
    step(1, 64'h7FFF_FFFF_3F80_0000, 2'b01, 1);   // R4 single zero at top
    step(1, 64'hFFFF_FFFE_3F80_0000, 2'b01, 1);   // R4 zero at bit 32
    step(1, 64'hFFFF_FFFF_FFFE_3C00, 2'b00, 1);   // R5 zero at bit 16
    step(1, 64'hFFFF_FFFF_3F80_0000, 2'b00, 1);   // R5 single-boxed read as half
    step(0, 64'h0000_0000_0000_0000, 2'b00, 1);   // idle: R7 hold
    step(0, 64'hDEAD_BEEF_0000_0001, 2'b01, 0);
    step(1, 64'h4009_21FB_5444_2D18, 2'b10, 0);   // R6
    step(1, 64'h4009_21FB_5444_2D18, 2'b11, 1);   // R6
    step(1, 64'h0000_0000_0000_0000, 2'b01, 1);   // R4
    step(1, 64'h0000_0000_0000_0000, 2'b00, 1);   // R5

    for (int i = 0; i < 400; i++) begin
      step(($urandom_range(3) != 0), rnd64($urandom_range(3)),
           2'($urandom_range(3)), 1'($urandom_range(1)));
    end
    step(0, '0, 2'b00, 0);
    step(0, '0, 2'b00, 0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule